// File: doc/BRIEF.md
# Three-colour linear CCD drive timing generator

This block turns a system clock into the digital drive waveforms of a three-colour linear CCD sensor. It produces the two complementary shift clocks, a reset-gate pulse, one transfer-gate pulse shared by all three colour rows, and the two colour-select lines. All of these are timed in whole clock cycles from a small set of configuration words. The configuration words are sampled once per line, so software can update them at any moment without tearing a line.

Each line starts with a one-cycle load slot. A transfer-gate pulse follows, and the shift clocks stay frozen during it. After that comes a hold window in which the shift clocks keep their frozen levels. Readout follows, pixel by pixel. The reset gate pulses at the start of every pixel period throughout the line, including while the transfer gate is high. The select lines work in one of two modes. In line mode they carry one colour for the whole line. In interleaved mode they step red, green, blue inside every pixel period. For the logic downstream, the block tags each readout pixel with its index and its region: dark reference, invalid or valid. The fixed readout layout is a leading invalid group, the dark group, a second invalid group, the valid group, and then invalid padding up to the programmed line length.

Top module: `ccd_line_timing`

## Requirements
- R1: In line mode the select pair {sel_a, sel_b} is 2'b01 for red (colour code 0), 2'b10 for green (code 1) and 2'b11 for blue (codes 2 and 3). The pair 2'b00 never appears on the outputs, whatever the mode, configuration or reset state.
- R2: In interleaved mode, with period length P and position k in the period (0..P-1), the select pair is red when 3k < P, green when P <= 3k < 2P, and blue otherwise.
- R3: During readout, phi1 is high for the first floor(P/2) cycles of each pixel period and low for the rest. phi2 is always the complement of phi1.
- R4: A line runs as one load cycle, then T cycles with tg high, then H cycles with tg low, then readout. Through load, transfer and hold, phi1 is high and phi2 is low.
- R5: The reset gate is high exactly when the period position k is below R. The position counts from 0 at the load cycle, keeps counting modulo P through transfer and hold, and restarts at 0 on the first readout cycle.
- R6: During readout, pix_idx gives the pixel number i and region gives the pixel's class (0 dark, 1 invalid, 2 valid). The classes run in this order: the first LEAD_INV pixels are invalid, the next DARK_PIX are dark, the next GAP_INV are invalid, the next VALID_PIX are valid, and the rest are invalid. Outside readout, region is 3 and pix_idx is 0.
- R7: Configuration inputs are sampled only at the end of the load cycle. Changes at any other time have no effect on the current line. The load cycle itself still shows the previous line's period, reset width, mode and colour.
- R8: line_start is high for exactly the load cycle. Readout lasts L x P cycles, and the next line's load cycle follows at once.
- R9: Outputs are registered. While reset is held, phi1=1, phi2=0, rst_gate=0, tg=0, select=2'b11, line_start=0, pix_idx=0 and region=3. After release, a two-stage synchroniser delays the first load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_pix_cyc | input | CYC_W | Pixel period P in clock cycles |
| cfg_tg_cyc | input | CYC_W | Transfer-gate width T in cycles |
| cfg_hold_cyc | input | CYC_W | Shift-clock hold window H after transfer, in cycles |
| cfg_rst_cyc | input | CYC_W | Reset-gate width R in cycles |
| cfg_line_pix | input | IDX_W | Pixels per line L, padding included |
| cfg_interleave | input | 1 | 1 selects per-pixel colour stepping |
| cfg_color | input | 2 | Line-mode colour code |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2 |
| rst_gate | output | 1 | Reset-gate pulse |
| tg | output | 1 | Transfer-gate pulse for all colour rows |
| sel_a | output | 1 | Colour select line A |
| sel_b | output | 1 | Colour select line B |
| line_start | output | 1 | High during the load cycle of each line |
| pix_idx | output | IDX_W | Readout pixel number |
| region | output | 2 | Pixel class tag |

## Verification
The assertions assume a legal configuration: P of at least 4, R of at least 1 and below P/2, T and H of at least 1, and L between the sum of the fixed groups and 2^IDX_W-1. Under these conditions the period counter stays below P, the select code is never zero, and the readout index stays below L. The stimulus uses only such settings, across a mix of periods, widths and both modes. It changes the configuration inputs in the middle of each line to an out-of-pattern but still legal set, so latching is tested without ever feeding an illegal value to a latched configuration.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_TG   = 2'd1,
    ST_HOLD = 2'd2,
    ST_READ = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    RG_DARK    = 2'd0,
    RG_INVALID = 2'd1,
    RG_VALID   = 2'd2,
    RG_IDLE    = 2'd3
  } region_t;

  localparam logic [1:0] SEL_RED   = 2'b01;
  localparam logic [1:0] SEL_GREEN = 2'b10;
  localparam logic [1:0] SEL_BLUE  = 2'b11;

  // Line-mode colour code to select pair; code 3 folds onto blue so 00 is unreachable.
  function automatic logic [1:0] color_to_sel(input logic [1:0] code);
    case (code)
      2'd0:    color_to_sel = SEL_RED;
      2'd1:    color_to_sel = SEL_GREEN;
      default: color_to_sel = SEL_BLUE;
    endcase
  endfunction

endpackage

// File: rtl/ccd_cfg_shadow.sv
module ccd_cfg_shadow #(
  parameter int CYC_W     = 16,
  parameter int IDX_W     = 12,
  parameter int DEF_PIX   = 100,
  parameter int DEF_TG    = 1000,
  parameter int DEF_HOLD  = 95,
  parameter int DEF_RST   = 4,
  parameter int DEF_LINE  = 2760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CYC_W-1:0] in_pix,
  input  logic [CYC_W-1:0] in_tg,
  input  logic [CYC_W-1:0] in_hold,
  input  logic [CYC_W-1:0] in_rst,
  input  logic [IDX_W-1:0] in_line,
  input  logic             in_interleave,
  input  logic [1:0]       in_color,
  output logic [CYC_W-1:0] sh_pix,
  output logic [CYC_W-1:0] sh_tg,
  output logic [CYC_W-1:0] sh_hold,
  output logic [CYC_W-1:0] sh_rst,
  output logic [IDX_W-1:0] sh_line,
  output logic             sh_interleave,
  output logic [1:0]       sh_color
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pix        <= CYC_W'(DEF_PIX);
      sh_tg         <= CYC_W'(DEF_TG);
      sh_hold       <= CYC_W'(DEF_HOLD);
      sh_rst        <= CYC_W'(DEF_RST);
      sh_line       <= IDX_W'(DEF_LINE);
      sh_interleave <= 1'b0;
      sh_color      <= 2'd2;
    end else if (load) begin
      sh_pix        <= in_pix;
      sh_tg         <= in_tg;
      sh_hold       <= in_hold;
      sh_rst        <= in_rst;
      sh_line       <= in_line;
      sh_interleave <= in_interleave;
      sh_color      <= in_color;
    end
  end

  // R7: latched settings move only on the load strobe
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(sh_pix) && $stable(sh_tg) && $stable(sh_hold) &&
               $stable(sh_rst) && $stable(sh_line) && $stable(sh_interleave) &&
               $stable(sh_color)));

endmodule

// File: rtl/ccd_period_ctr.sv
module ccd_period_ctr #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] period,
  input  logic             restart,
  output logic [CYC_W-1:0] pcnt,
  output logic             wrap
);

  logic [CYC_W-1:0] pcnt_nxt;

  always_comb begin
    wrap = (pcnt == period - 1'b1);
    if (restart || wrap) pcnt_nxt = '0;
    else                 pcnt_nxt = pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt_nxt;
  end

  // R5: period position stays inside the latched period
  a_r5_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < period);

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tg_pkg::*;
#(
  parameter int CYC_W = 16,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] tg_len,
  input  logic [CYC_W-1:0] hold_len,
  input  logic [IDX_W-1:0] line_len,
  input  logic             wrap,
  output seq_state_t       state,
  output logic [IDX_W-1:0] pidx,
  output logic             load,
  output logic             restart
);

  seq_state_t       state_nxt;
  logic [CYC_W-1:0] tcnt, tcnt_nxt;
  logic [IDX_W-1:0] pidx_nxt;

  always_comb begin
    state_nxt = state;
    tcnt_nxt  = tcnt;
    pidx_nxt  = pidx;
    load      = 1'b0;
    restart   = 1'b0;
    case (state)
      ST_LOAD: begin
        load      = 1'b1;
        state_nxt = ST_TG;
        tcnt_nxt  = '0;
      end
      ST_TG: begin
        if (tcnt == tg_len - 1'b1) begin
          state_nxt = ST_HOLD;
          tcnt_nxt  = '0;
        end else begin
          tcnt_nxt = tcnt + 1'b1;
        end
      end
      ST_HOLD: begin
        if (tcnt == hold_len - 1'b1) begin
          state_nxt = ST_READ;
          restart   = 1'b1;
          pidx_nxt  = '0;
        end else begin
          tcnt_nxt = tcnt + 1'b1;
        end
      end
      default: begin
        if (wrap) begin
          if (pidx == line_len - 1'b1) state_nxt = ST_LOAD;
          else                         pidx_nxt  = pidx + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      tcnt  <= '0;
      pidx  <= '0;
    end else begin
      state <= state_nxt;
      tcnt  <= tcnt_nxt;
      pidx  <= pidx_nxt;
    end
  end

  // R8: readout index never passes the programmed line length
  a_r8_idx_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |-> (pidx < line_len));

  // R4: readout is only entered from the hold window
  a_r4_hold_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_READ) |-> ($past(state) == ST_HOLD));

  // R8: the load slot lasts a single cycle and leads into transfer
  a_r8_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> (state == ST_TG));

endmodule

// File: rtl/ccd_drive_out.sv
module ccd_drive_out
  import ccd_tg_pkg::*;
#(
  parameter int CYC_W     = 16,
  parameter int IDX_W     = 12,
  parameter int LEAD_INV  = 3,
  parameter int DARK_PIX  = 48,
  parameter int GAP_INV   = 2,
  parameter int VALID_PIX = 2700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_t       state,
  input  logic [CYC_W-1:0] pcnt,
  input  logic [IDX_W-1:0] pidx,
  input  logic [CYC_W-1:0] sh_pix,
  input  logic [CYC_W-1:0] sh_rst,
  input  logic             sh_interleave,
  input  logic [1:0]       sh_color,
  output logic             phi1_q,
  output logic             phi2_q,
  output logic             rst_gate_q,
  output logic             tg_q,
  output logic [1:0]       sel_q,
  output logic             line_start_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [1:0]       region_q
);

  localparam int B_DARK  = LEAD_INV;
  localparam int B_GAP   = B_DARK + DARK_PIX;
  localparam int B_VALID = B_GAP + GAP_INV;
  localparam int B_PAD   = B_VALID + VALID_PIX;

  logic             phi1_d, phi2_d, rst_d, tg_d, ls_d;
  logic [1:0]       sel_d;
  logic [IDX_W-1:0] idx_d;
  region_t          region_d;
  logic [CYC_W-1:0] half;
  logic [CYC_W+1:0] pos3, per1, per2;
  logic             reading;

  always_comb begin
    reading = (state == ST_READ);
    half    = sh_pix >> 1;
    phi1_d  = !reading || (pcnt < half);
    phi2_d  = reading && (pcnt >= half);
    rst_d   = (pcnt < sh_rst);
    tg_d    = (state == ST_TG);
    ls_d    = (state == ST_LOAD);
    // colour slot: compare 3k against P and 2P
    pos3 = ({2'b00, pcnt} << 1) + {2'b00, pcnt};
    per1 = {2'b00, sh_pix};
    per2 = per1 << 1;
    if (sh_interleave) begin
      if (pos3 < per1)      sel_d = SEL_RED;
      else if (pos3 < per2) sel_d = SEL_GREEN;
      else                  sel_d = SEL_BLUE;
    end else begin
      sel_d = color_to_sel(sh_color);
    end
    idx_d = reading ? pidx : '0;
    if (!reading)                      region_d = RG_IDLE;
    else if (pidx < IDX_W'(B_DARK))    region_d = RG_INVALID;
    else if (pidx < IDX_W'(B_GAP))     region_d = RG_DARK;
    else if (pidx < IDX_W'(B_VALID))   region_d = RG_INVALID;
    else if (pidx < IDX_W'(B_PAD))     region_d = RG_VALID;
    else                               region_d = RG_INVALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi1_q       <= 1'b1;
      phi2_q       <= 1'b0;
      rst_gate_q   <= 1'b0;
      tg_q         <= 1'b0;
      sel_q        <= SEL_BLUE;
      line_start_q <= 1'b0;
      idx_q        <= '0;
      region_q     <= RG_IDLE;
    end else begin
      phi1_q       <= phi1_d;
      phi2_q       <= phi2_d;
      rst_gate_q   <= rst_d;
      tg_q         <= tg_d;
      sel_q        <= sel_d;
      line_start_q <= ls_d;
      idx_q        <= idx_d;
      region_q     <= region_d;
    end
  end

  // R1: the prohibited select pair is never driven
  a_r1_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != 2'b00);

  // R3: the two shift clock phases are never equal
  a_r3_phases_opposed: assert property (@(posedge clk) disable iff (!rst_n)
    phi1_q != phi2_q);

  // R4: shift clocks frozen while the transfer gate is open
  a_r4_tg_freezes_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    tg_q |-> (phi1_q && !phi2_q));

  // R8: the line strobe is a single-cycle pulse
  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_q |=> !line_start_q);

  // R6: outside readout the index reads zero
  a_r6_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
    (region_q == RG_IDLE) |-> (idx_q == '0));

endmodule

// File: rtl/ccd_line_timing.sv
module ccd_line_timing
  import ccd_tg_pkg::*;
#(
  parameter int CYC_W     = 16,
  parameter int IDX_W     = 12,
  parameter int LEAD_INV  = 3,
  parameter int DARK_PIX  = 48,
  parameter int GAP_INV   = 2,
  parameter int VALID_PIX = 2700,
  parameter int DEF_PIX   = 100,
  parameter int DEF_TG    = 1000,
  parameter int DEF_HOLD  = 95,
  parameter int DEF_RST   = 4,
  parameter int DEF_LINE  = 2760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cfg_pix_cyc,
  input  logic [CYC_W-1:0] cfg_tg_cyc,
  input  logic [CYC_W-1:0] cfg_hold_cyc,
  input  logic [CYC_W-1:0] cfg_rst_cyc,
  input  logic [IDX_W-1:0] cfg_line_pix,
  input  logic             cfg_interleave,
  input  logic [1:0]       cfg_color,
  output logic             phi1,
  output logic             phi2,
  output logic             rst_gate,
  output logic             tg,
  output logic             sel_a,
  output logic             sel_b,
  output logic             line_start,
  output logic [IDX_W-1:0] pix_idx,
  output logic [1:0]       region
);

  logic [1:0] rsync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  logic [CYC_W-1:0] sh_pix, sh_tg, sh_hold, sh_rst, pcnt;
  logic [IDX_W-1:0] sh_line, pidx;
  logic             sh_interleave, load, restart, wrap;
  logic [1:0]       sh_color, sel_q;
  seq_state_t       state;

  ccd_cfg_shadow #(
    .CYC_W(CYC_W), .IDX_W(IDX_W), .DEF_PIX(DEF_PIX), .DEF_TG(DEF_TG),
    .DEF_HOLD(DEF_HOLD), .DEF_RST(DEF_RST), .DEF_LINE(DEF_LINE)
  ) u_shadow (
    .clk(clk), .rst_n(rst_int_n), .load(load),
    .in_pix(cfg_pix_cyc), .in_tg(cfg_tg_cyc), .in_hold(cfg_hold_cyc),
    .in_rst(cfg_rst_cyc), .in_line(cfg_line_pix),
    .in_interleave(cfg_interleave), .in_color(cfg_color),
    .sh_pix(sh_pix), .sh_tg(sh_tg), .sh_hold(sh_hold), .sh_rst(sh_rst),
    .sh_line(sh_line), .sh_interleave(sh_interleave), .sh_color(sh_color)
  );

  ccd_period_ctr #(.CYC_W(CYC_W)) u_period (
    .clk(clk), .rst_n(rst_int_n), .period(sh_pix), .restart(restart),
    .pcnt(pcnt), .wrap(wrap)
  );

  ccd_line_seq #(.CYC_W(CYC_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .tg_len(sh_tg), .hold_len(sh_hold),
    .line_len(sh_line), .wrap(wrap), .state(state), .pidx(pidx),
    .load(load), .restart(restart)
  );

  ccd_drive_out #(
    .CYC_W(CYC_W), .IDX_W(IDX_W), .LEAD_INV(LEAD_INV), .DARK_PIX(DARK_PIX),
    .GAP_INV(GAP_INV), .VALID_PIX(VALID_PIX)
  ) u_drive (
    .clk(clk), .rst_n(rst_int_n), .state(state), .pcnt(pcnt), .pidx(pidx),
    .sh_pix(sh_pix), .sh_rst(sh_rst), .sh_interleave(sh_interleave),
    .sh_color(sh_color), .phi1_q(phi1), .phi2_q(phi2), .rst_gate_q(rst_gate),
    .tg_q(tg), .sel_q(sel_q), .line_start_q(line_start), .idx_q(pix_idx),
    .region_q(region)
  );

  assign sel_a = sel_q[1];
  assign sel_b = sel_q[0];

endmodule

// File: tb/tb_ccd_line_timing.sv
module tb_ccd_line_timing;

  localparam int CW = 16;
  localparam int IW = 12;
  localparam int LEAD = 3, DARK = 4, GAP = 2, VAL = 10;
  localparam int D_P = 8, D_T = 4, D_H = 2, D_R = 2, D_L = 20;
  localparam int NLINES = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [CW-1:0] cfg_pix_cyc, cfg_tg_cyc, cfg_hold_cyc, cfg_rst_cyc;
  logic [IW-1:0] cfg_line_pix;
  logic          cfg_interleave;
  logic [1:0]    cfg_color;
  logic          phi1, phi2, rst_gate, tg, sel_a, sel_b, line_start;
  logic [IW-1:0] pix_idx;
  logic [1:0]    region;

  ccd_line_timing #(
    .CYC_W(CW), .IDX_W(IW), .LEAD_INV(LEAD), .DARK_PIX(DARK), .GAP_INV(GAP),
    .VALID_PIX(VAL), .DEF_PIX(D_P), .DEF_TG(D_T), .DEF_HOLD(D_H),
    .DEF_RST(D_R), .DEF_LINE(D_L)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_pix_cyc(cfg_pix_cyc), .cfg_tg_cyc(cfg_tg_cyc),
    .cfg_hold_cyc(cfg_hold_cyc), .cfg_rst_cyc(cfg_rst_cyc),
    .cfg_line_pix(cfg_line_pix), .cfg_interleave(cfg_interleave),
    .cfg_color(cfg_color), .phi1(phi1), .phi2(phi2), .rst_gate(rst_gate),
    .tg(tg), .sel_a(sel_a), .sel_b(sel_b), .line_start(line_start),
    .pix_idx(pix_idx), .region(region)
  );

  typedef struct {
    int p; int t; int h; int r; int l; bit il; int col;
  } lcfg_t;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic lcfg_t mk(int p, int t, int h, int r, int l, bit il, int col);
    lcfg_t c;
    c.p = p; c.t = t; c.h = h; c.r = r; c.l = l; c.il = il; c.col = col;
    return c;
  endfunction

  function automatic lcfg_t line_cfg(int n);
    case (n)
      0:       return mk(4, 3, 2, 1, 19, 1'b0, 0);
      1:       return mk(5, 5, 1, 2, 20, 1'b0, 1);
      2:       return mk(6, 2, 3, 1, 22, 1'b0, 2);
      3:       return mk(7, 4, 2, 3, 19, 1'b0, 3);
      4:       return mk(6, 3, 3, 2, 21, 1'b1, 0);
      5:       return mk(7, 1, 1, 1, 19, 1'b1, 1);
      6:       return mk(9, 6, 4, 4, 23, 1'b1, 2);
      default: return mk(4, 2, 1, 1, 19, 1'b1, 3);
    endcase
  endfunction

  task automatic drive(lcfg_t c);
    cfg_pix_cyc    = CW'(c.p);
    cfg_tg_cyc     = CW'(c.t);
    cfg_hold_cyc   = CW'(c.h);
    cfg_rst_cyc    = CW'(c.r);
    cfg_line_pix   = IW'(c.l);
    cfg_interleave = c.il;
    cfg_color      = 2'(c.col);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R1/R2: expected select pair as {sel_a, sel_b}
  function automatic int exp_sel(lcfg_t c, int k);
    if (c.il) begin
      if (3 * k < c.p)          return 1;
      else if (3 * k < 2 * c.p) return 2;
      else                      return 3;
    end
    if (c.col == 0) return 1;
    if (c.col == 1) return 2;
    return 3;
  endfunction

  // R6: expected class of readout pixel i
  function automatic int exp_region(int i);
    if (i < LEAD)                   return 1;
    if (i < LEAD + DARK)            return 0;
    if (i < LEAD + DARK + GAP)      return 1;
    if (i < LEAD + DARK + GAP + VAL) return 2;
    return 1;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(line_cfg(0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: values held during reset
    chk("R9 phi1", 32'(phi1), 1);
    chk("R9 phi2", 32'(phi2), 0);
    chk("R9 rst_gate", 32'(rst_gate), 0);
    chk("R9 tg", 32'(tg), 0);
    chk("R9 sel", 32'({sel_a, sel_b}), 3);
    chk("R9 line_start", 32'(line_start), 0);
    chk("R9 pix_idx", 32'(pix_idx), 0);
    chk("R9 region", 32'(region), 3);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int n = 0; n < NLINES; n++) begin
      lcfg_t c, pv, junk;
      int pre, total;
      bit junk_on;
      c     = line_cfg(n);
      pv    = (n == 0) ? mk(D_P, D_T, D_H, D_R, D_L, 1'b0, 2) : line_cfg(n - 1);
      junk  = mk(12, 9, 9, 5, 30, !c.il, (c.col + 1) % 4);
      pre   = 1 + c.t + c.h;
      total = pre + c.l * c.p;
      junk_on = 1'b0;
      for (int j = 0; j < total; j++) begin
        int e_tg, e_p1, e_rst, e_sel, e_ls, e_idx, e_reg, k;
        string st_sel, st_rst;
        @(posedge clk);
        @(negedge clk);
        if (j == 0) begin
          // load cycle still reflects the previous line's settings (R7)
          e_tg = 0; e_p1 = 1; e_rst = (0 < pv.r) ? 1 : 0;
          e_sel = exp_sel(pv, 0); e_ls = 1; e_idx = 0; e_reg = 3;
        end else if (j < pre) begin
          k = j % c.p;
          e_tg = (j < 1 + c.t) ? 1 : 0; e_p1 = 1;
          e_rst = (k < c.r) ? 1 : 0; e_sel = exp_sel(c, k);
          e_ls = 0; e_idx = 0; e_reg = 3;
        end else begin
          k = (j - pre) % c.p;
          e_tg = 0; e_p1 = (k < c.p / 2) ? 1 : 0;
          e_rst = (k < c.r) ? 1 : 0; e_sel = exp_sel(c, k);
          e_ls = 0; e_idx = (j - pre) / c.p; e_reg = exp_region(e_idx);
        end
        st_sel = junk_on ? "R7 sel" : (c.il ? "R2 sel" : "R1 sel");
        st_rst = junk_on ? "R7 rst_gate" : "R5 rst_gate";
        chk("R4 tg", 32'(tg), e_tg);
        chk((j < pre) ? "R4 phi1" : "R3 phi1", 32'(phi1), e_p1);
        chk("R3 phi2", 32'(phi2), 1 - e_p1);
        chk(st_rst, 32'(rst_gate), e_rst);
        chk(st_sel, 32'({sel_a, sel_b}), e_sel);
        chk("R8 line_start", 32'(line_start), e_ls);
        chk("R6 pix_idx", 32'(pix_idx), e_idx);
        chk("R6 region", 32'(region), e_reg);
        if (j == 0) begin
          drive(junk);
          junk_on = 1'b1;
        end
        if (j == total - 2) begin
          drive(line_cfg(n + 1));
          junk_on = 1'b0;
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule